// File: doc/BRIEF.md
# Vehicle Access Gate Controller

This block is a clocked Moore state machine that drives the motor of a vehicle barrier. It watches four inputs: a driver's push button, a limit switch that closes when the barrier is fully up, a limit switch that closes when the barrier is fully down, and a presence detector covering the area under the barrier. From these it drives two outputs: a motor power enable and a travel direction.

Every pass through the machine follows the same path. It waits in idle for a button press and then raises the barrier until the top limit is reached. With the motor off, it holds the barrier open until the area is empty. It then lowers the barrier until the bottom limit is reached and goes back to idle. Once a pass has started, nothing can cut it short: a button press is only heard in idle.

Each step listens to exactly one input. The outputs are registered and depend only on the phase the machine is in. The state register can be built binary or one-hot, and each input can be declared active-low. Neither option changes what the ports show.

Top module: `gate_access_ctrl`

## Requirements
- R1: With `rst_i` high at a rising clock edge, the machine enters idle at that edge and both outputs read 0 after it, whatever phase it was in before.
- R2: In idle, a rising edge with `req_i`=1 moves the machine to raising, where `motor_en_o`=1 and `motor_dir_o`=0. With `req_i`=0 it stays in idle with both outputs 0.
- R3: The raising phase holds while `top_lim_i`=0. At the first edge with `top_lim_i`=1 the machine moves to the hold-open phase, where both outputs are 0.
- R4: The hold-open phase holds while `occupied_i`=1. At the first edge with `occupied_i`=0 the machine moves to lowering, where `motor_en_o`=1 and `motor_dir_o`=1.
- R5: The lowering phase holds while `bot_lim_i`=0. At the first edge with `bot_lim_i`=1 the machine returns to idle, where both outputs are 0.
- R6: `req_i` has no effect in the raising, hold-open and lowering phases. The pass cannot be restarted or interrupted by the button.
- R7: In each phase only that phase's own input (listed in R2 to R5) decides the next phase. Every other input is ignored.
- R8: `motor_dir_o` is 0 whenever `motor_en_o` is 0. The output pair therefore only takes the values 0/0, 1/0 and 1/1, and the outputs change only at rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Driver button, 1 = pressed |
| top_lim_i | input | 1 | 1 = barrier fully raised |
| bot_lim_i | input | 1 | 1 = barrier fully lowered |
| occupied_i | input | 1 | 1 = vehicle present in the barrier area |
| motor_en_o | output | 1 | Motor power, 1 = on |
| motor_dir_o | output | 1 | Travel direction, 0 = raise, 1 = lower (0 while off) |

## Verification
Idle and hold-open look the same at the ports (motor off), so a machine stuck in the wrong one of the two shows nothing until the next input event. It only gives itself away when a button press starts no motion, or when a clear area fails to start lowering. In either case the error appears on the outputs one clock edge after that input. The bench therefore keeps its own model of the phase and drives random sequences that repeatedly visit both motor-off phases with each deciding input. A wrong direction or a missed limit shows up at the edge right after the limit input changes.

// File: rtl/gate_ctrl_pkg.sv
package gate_ctrl_pkg;

   localparam int unsigned NUM_PHASES = 4;
   localparam int unsigned PHASE_W    = $clog2(NUM_PHASES);
   localparam int unsigned NUM_SENSE  = 4;

   // positions inside the normalized sense vector
   localparam int unsigned SENSE_REQ = 0;
   localparam int unsigned SENSE_TOP = 1;
   localparam int unsigned SENSE_BOT = 2;
   localparam int unsigned SENSE_OCC = 3;

   localparam logic DIR_RAISE = 1'b0;
   localparam logic DIR_LOWER = 1'b1;

   // state encoding options for the phase register
   localparam int unsigned ENC_BINARY = 0;
   localparam int unsigned ENC_ONEHOT = 1;

   typedef enum logic [PHASE_W-1:0] {
      PH_IDLE  = 2'd0,
      PH_RAISE = 2'd1,
      PH_HOLD  = 2'd2,
      PH_LOWER = 2'd3
   } gate_phase_e;

   typedef struct packed {
      logic en;
      logic dir;
   } motor_cmd_t;

   function automatic motor_cmd_t cmd_for(gate_phase_e ph);
      motor_cmd_t c;
      c.en  = 1'b0;
      c.dir = DIR_RAISE;
      unique case (ph)
         PH_RAISE: begin c.en = 1'b1; c.dir = DIR_RAISE; end
         PH_LOWER: begin c.en = 1'b1; c.dir = DIR_LOWER; end
         default:  begin c.en = 1'b0; c.dir = DIR_RAISE; end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/gate_sense_norm.sv
module gate_sense_norm
   import gate_ctrl_pkg::*;
#(
   parameter int unsigned             WIDTH      = NUM_SENSE,
   parameter logic [NUM_SENSE-1:0]    ACTIVE_LOW = '0
) (
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] norm_o
);

   if (WIDTH != NUM_SENSE) begin : g_bad_width
      $error("gate_sense_norm: WIDTH must equal NUM_SENSE");
   end

   for (genvar k = 0; k < WIDTH; k++) begin : g_bit
      if (ACTIVE_LOW[k]) begin : g_inv
         assign norm_o[k] = ~raw_i[k];
      end else begin : g_pass
         assign norm_o[k] = raw_i[k];
      end
   end

endmodule

// File: rtl/gate_step_logic.sv
module gate_step_logic
   import gate_ctrl_pkg::*;
(
   input  gate_phase_e          cur_i,
   input  logic [NUM_SENSE-1:0] sense_i,
   output gate_phase_e          nxt_o
);

   logic pressed, at_top, at_bot, occupied;

   assign pressed  = sense_i[SENSE_REQ];
   assign at_top   = sense_i[SENSE_TOP];
   assign at_bot   = sense_i[SENSE_BOT];
   assign occupied = sense_i[SENSE_OCC];

   // each phase listens to one input only
   always_comb begin
      nxt_o = cur_i;
      unique case (cur_i)
         PH_IDLE:  if (pressed)   nxt_o = PH_RAISE;
         PH_RAISE: if (at_top)    nxt_o = PH_HOLD;
         PH_HOLD:  if (!occupied) nxt_o = PH_LOWER;
         PH_LOWER: if (at_bot)    nxt_o = PH_IDLE;
         default:                 nxt_o = PH_IDLE;
      endcase
   end

endmodule

// File: rtl/gate_phase_reg.sv
module gate_phase_reg
   import gate_ctrl_pkg::*;
#(
   parameter int unsigned STATE_ENC = ENC_BINARY
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  gate_phase_e           nxt_i,
   output gate_phase_e           cur_o,
   output logic [NUM_PHASES-1:0] flags_o
);

   if (STATE_ENC != ENC_BINARY && STATE_ENC != ENC_ONEHOT) begin : g_bad_enc
      $error("gate_phase_reg: STATE_ENC must be ENC_BINARY or ENC_ONEHOT");
   end

   if (STATE_ENC == ENC_ONEHOT) begin : g_onehot
      logic [NUM_PHASES-1:0] q;

      always_ff @(posedge clk_i) begin
         if (rst_i) q <= NUM_PHASES'(1);
         else       q <= NUM_PHASES'(1) << nxt_i;
      end

      always_comb begin
         cur_o = PH_IDLE;
         for (int k = 0; k < NUM_PHASES; k++) begin
            if (q[k]) cur_o = gate_phase_e'(PHASE_W'(k));
         end
      end

      assign flags_o = q;
   end else begin : g_binary
      logic [PHASE_W-1:0] q;

      always_ff @(posedge clk_i) begin
         if (rst_i) q <= PH_IDLE;
         else       q <= nxt_i;
      end

      assign cur_o = gate_phase_e'(q);

      for (genvar k = 0; k < NUM_PHASES; k++) begin : g_flag
         assign flags_o[k] = (q == PHASE_W'(k));
      end
   end

endmodule

// File: rtl/gate_cmd_reg.sv
module gate_cmd_reg
   import gate_ctrl_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_i,
   input  gate_phase_e nxt_i,
   output logic        en_o,
   output logic        dir_o
);

   motor_cmd_t cmd_d, cmd_q;

   // decoded from the phase being entered, so it lines up with the phase register
   assign cmd_d = cmd_for(nxt_i);

   always_ff @(posedge clk_i) begin
      if (rst_i) cmd_q <= '0;
      else       cmd_q <= cmd_d;
   end

   assign en_o  = cmd_q.en;
   assign dir_o = cmd_q.dir;

endmodule

// File: rtl/gate_access_ctrl.sv
module gate_access_ctrl
   import gate_ctrl_pkg::*;
#(
   parameter int unsigned          STATE_ENC  = ENC_BINARY,
   parameter logic [NUM_SENSE-1:0] ACTIVE_LOW = '0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic req_i,
   input  logic top_lim_i,
   input  logic bot_lim_i,
   input  logic occupied_i,
   output logic motor_en_o,
   output logic motor_dir_o
);

   logic [NUM_SENSE-1:0]  sense_raw, sense_n;
   logic [NUM_PHASES-1:0] phase_flags;
   gate_phase_e           phase_cur, phase_nxt;

   always_comb begin
      sense_raw            = '0;
      sense_raw[SENSE_REQ] = req_i;
      sense_raw[SENSE_TOP] = top_lim_i;
      sense_raw[SENSE_BOT] = bot_lim_i;
      sense_raw[SENSE_OCC] = occupied_i;
   end

   gate_sense_norm #(
      .WIDTH     (NUM_SENSE),
      .ACTIVE_LOW(ACTIVE_LOW)
   ) u_norm (
      .raw_i (sense_raw),
      .norm_o(sense_n)
   );

   gate_step_logic u_step (
      .cur_i  (phase_cur),
      .sense_i(sense_n),
      .nxt_o  (phase_nxt)
   );

   gate_phase_reg #(
      .STATE_ENC(STATE_ENC)
   ) u_phase (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .nxt_i  (phase_nxt),
      .cur_o  (phase_cur),
      .flags_o(phase_flags)
   );

   gate_cmd_reg u_cmd (
      .clk_i(clk_i),
      .rst_i(rst_i),
      .nxt_i(phase_nxt),
      .en_o (motor_en_o),
      .dir_o(motor_dir_o)
   );

endmodule

// File: rtl/gate_access_ctrl_chk.sv
module gate_access_ctrl_chk
   import gate_ctrl_pkg::*;
(
   input logic                  clk_i,
   input logic                  rst_i,
   input logic [NUM_SENSE-1:0]  sense_i,
   input logic [NUM_PHASES-1:0] flags_i,
   input logic                  en_i,
   input logic                  dir_i
);

   logic in_idle, in_raise, in_hold, in_lower;
   assign in_idle  = flags_i[PH_IDLE];
   assign in_raise = flags_i[PH_RAISE];
   assign in_hold  = flags_i[PH_HOLD];
   assign in_lower = flags_i[PH_LOWER];

   AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (in_idle && !en_i && !dir_i)); // R1
   AST_REQ_STARTS_RAISE: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_idle && sense_i[SENSE_REQ]) |=> (in_raise && en_i && !dir_i)); // R2
   AST_IDLE_WAITS: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_idle && !sense_i[SENSE_REQ]) |=> (in_idle && !en_i)); // R2
   AST_RAISE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_raise && !sense_i[SENSE_TOP]) |=> (in_raise && en_i && !dir_i)); // R3
   AST_RAISE_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_raise && sense_i[SENSE_TOP]) |=> (in_hold && !en_i)); // R3
   AST_HOLD_WAITS: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_hold && sense_i[SENSE_OCC]) |=> (in_hold && !en_i)); // R4
   AST_LOWER_START: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_hold && !sense_i[SENSE_OCC]) |=> (in_lower && en_i && dir_i)); // R4
   AST_LOWER_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_lower && !sense_i[SENSE_BOT]) |=> (in_lower && en_i && dir_i)); // R5
   AST_LOWER_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_lower && sense_i[SENSE_BOT]) |=> (in_idle && !en_i)); // R5
   AST_REQ_NO_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
      (!in_idle && sense_i[SENSE_REQ]) |=> !$rose(in_raise)); // R6
   AST_DIR_LOW_WHEN_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |-> !dir_i); // R8
   AST_SINGLE_PHASE: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(flags_i) == 1); // R7

endmodule

bind gate_access_ctrl gate_access_ctrl_chk u_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .sense_i(sense_n),
   .flags_i(phase_flags),
   .en_i   (motor_en_o),
   .dir_i  (motor_dir_o)
);

// File: tb/gate_access_ctrl_tb_top.sv
module gate_access_ctrl_tb_top;

   logic clk = 1'b0;
   logic rst, req, top_lim, bot_lim, occ;
   logic en, dir;

   int errors = 0;
   int checks = 0;
   int m_ph   = 0; // 0 idle, 1 raise, 2 hold-open, 3 lower

   always #5 clk = ~clk;

   gate_access_ctrl dut_i (
      .clk_i      (clk),
      .rst_i      (rst),
      .req_i      (req),
      .top_lim_i  (top_lim),
      .bot_lim_i  (bot_lim),
      .occupied_i (occ),
      .motor_en_o (en),
      .motor_dir_o(dir)
   );

   function automatic int model_next(int ph, logic r, logic t, logic b, logic o);
      case (ph)
         0: return r ? 1 : 0;
         1: return t ? 2 : 1;
         2: return o ? 2 : 3;
         default: return b ? 0 : 3;
      endcase
   endfunction

   function automatic logic [1:0] model_out(int ph);
      case (ph)
         1: return 2'b10;
         3: return 2'b11;
         default: return 2'b00;
      endcase
   endfunction

   function automatic string model_tag(int ph, logic r);
      if (ph != 0 && r) return "R6";
      case (ph)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic check_out(string tag, logic [1:0] exp);
      checks++;
      if ({en, dir} !== exp) begin
         errors++;
         $display("FAIL %s: en/dir actual=%b%b expected=%b", tag, en, dir, exp);
      end
      checks++;
      if (!en && dir) begin
         errors++;
         $display("FAIL R8: dir=1 with motor off actual=%b%b expected=00", en, dir);
      end
   endtask

   // called at a falling edge; drives, waits one clock, checks at the next falling edge
   task automatic step(logic r, logic t, logic b, logic o, string tag);
      int nx;
      string tg;
      rst = 1'b0; req = r; top_lim = t; bot_lim = b; occ = o;
      nx = model_next(m_ph, r, t, b, o);
      tg = (tag == "") ? model_tag(m_ph, r) : tag;
      @(negedge clk);
      m_ph = nx;
      check_out(tg, model_out(m_ph));
   endtask

   task automatic do_reset(logic r, logic t, logic b, logic o);
      rst = 1'b1; req = r; top_lim = t; bot_lim = b; occ = o;
      @(negedge clk);
      m_ph = 0;
      check_out("R1", 2'b00);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd7741);
      rst = 1'b1; req = 0; top_lim = 0; bot_lim = 0; occ = 0;
      @(negedge clk);
      @(negedge clk);
      m_ph = 0;
      check_out("R1", 2'b00);

      // directed: full pass with holds in every phase (R2..R5)
      step(0, 1, 1, 0, "R2");   // idle ignores limits, clear area
      step(1, 0, 0, 1, "R2");   // -> raise
      step(0, 0, 1, 0, "R7");   // raise ignores bottom limit and clear area
      step(1, 0, 0, 1, "R6");   // button during raise
      step(0, 1, 0, 1, "R3");   // -> hold-open
      step(1, 0, 0, 1, "R6");   // button while occupied: stays put
      step(0, 1, 1, 1, "R7");   // hold ignores limits
      step(0, 0, 0, 0, "R4");   // -> lower
      step(1, 1, 0, 0, "R7");   // lower ignores top limit and button
      step(0, 0, 1, 1, "R5");   // -> idle
      step(0, 0, 0, 0, "R2");   // stays idle
      // back-to-back pass with every decision on the first cycle
      step(1, 1, 0, 0, "R2");
      step(0, 1, 0, 0, "R3");
      step(1, 0, 1, 0, "R4");
      step(1, 0, 1, 0, "R5");
      // reset in the middle of lowering
      step(1, 0, 0, 0, "R2");
      step(0, 1, 0, 0, "R3");
      step(0, 0, 0, 0, "R4");
      do_reset(1, 1, 1, 1);
      step(0, 0, 0, 1, "R1");   // still idle after reset
      step(1, 0, 0, 0, "R1");   // accepts a fresh request

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic r, t, b, o;
         r = ($urandom % 3) == 0;
         t = ($urandom % 4) == 0;
         b = ($urandom % 4) == 0;
         o = ($urandom % 3) != 0;
         if (($urandom % 97) == 0) do_reset(r, t, b, o);
         else                      step(r, t, b, o, "");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule